// File: doc/BRIEF.md
# PWM generator with buffered duty samples

This block is a pulse-width modulator on a small 32-bit register bus. Software sets a period and a prescaler, then queues duty values into a four-entry sample queue. A tick counter runs on the prescaled clock. Each period starts with the counter at zero. The output is active while the counter is below the duty value in use.

The duty value in use is replaced only at a period boundary. A value is taken from the queue when the generator is switched on and again at every counter wrap. When the queue is empty, the last duty value stays in effect. A polarity bit inverts the active level. A self-clearing reset bit returns the control state, the queue and the counter to zero. Debug, wait, doze and stop mode enables are kept in the control word and can be read back, but they change nothing.

Top module: `pwm_fifo_gen`

## Requirements
- R1: Registers are decoded from byte addresses: control at 0x00, status at 0x04, sample at 0x0C and period at 0x10. Read data is combinational while the read strobe is high. The period register holds the low 16 bits of the written value. A read of the sample register returns the duty value in use. A read of any other address returns 0.
- R2: The control word has these fields: enable at bit 0, reset at bit 3, prescaler at bits 15:4, clock source at bits 17:16, polarity at bit 18, and mode enables at bits 25:22. All of them read back as written. Every other bit reads 0. The mode enables have no effect on the output.
- R3: Each write to the sample register adds one entry to the queue. Status bits 2:0 give the number of entries held, and that number never exceeds 4. A write made while 4 entries are held is dropped.
- R4: With prescaler field P and period value T, one output period lasts (T+2)*(P+1) clock cycles. The counter steps once every P+1 cycles and runs from 0 to T+1.
- R5: On the write that sets enable while the generator is disabled, the head of the queue becomes the duty value D. The same happens at each counter wrap while the queue is not empty. When the queue is empty, D is kept. With polarity 0, the output is 1 while the counter is below D.
- R6: When polarity bit 18 is set, the active level of the enabled output is inverted.
- R7: While enable is 0, the output is 0 whatever the polarity, and the counter is held at 0. Writing 0 to the control register disables the output.
- R8: Writing control bit 3 starts a reset. Bit 3 reads 1 in the next cycle. One cycle later bit 3 reads 0 and the control word is 0. At that point the queue is empty, the counter is at 0, the duty value is 0 and the output is low. The period register keeps its value.
- R9: When the clock source field is 0, the counter does not advance, so the output stays at its counter-zero level.
- R10: After the hardware reset, every register reads 0 and the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 5 | Byte address of the register |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, 0 while the read strobe is low |
| pwmOut | output | 1 | PWM output |

## Verification
The hardest behaviour to reach from the ports combines a dropped write at a full queue with the hold of the last duty value once the queue has drained. Both are visible only several periods after the fact. To reach them, the bench fills the queue before enabling and pushes a fifth value that is chosen to differ from the fourth. It then checks every cycle of five whole periods against the counter position it computes itself. A leaked fifth value, a lost hold or a wrong pop time therefore shows up as a wrong output level in the last period.

// File: rtl/pwm_fifo_pkg.sv
`timescale 1ns/1ps
package pwm_fifo_pkg;
  localparam int PRESC_W = 12;
  localparam int SRC_W   = 2;
  localparam int MODE_W  = 4;
  localparam int ADDR_W  = 5;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_SAMPLE = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_PERIOD = 5'h10;

  localparam int BIT_EN    = 0;
  localparam int BIT_SWR   = 3;
  localparam int PRESC_LSB = 4;
  localparam int SRC_LSB   = 16;
  localparam int BIT_POL   = 18;
  localparam int MODE_LSB  = 22;
  localparam int CTRL_TOP  = MODE_LSB + MODE_W;

  typedef struct packed {
    logic               en;
    logic [PRESC_W-1:0] presc;
    logic [SRC_W-1:0]   clkSrc;
    logic               pol;
  } pwmCfg_t;

  typedef struct packed {
    logic swReset;
    logic push;
    logic enStart;
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_sample_fifo.sv
`timescale 1ns/1ps
module pwm_sample_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count,
  output logic             empty
);
  logic [WIDTH-1:0] slot [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic full, doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = slot[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (doPush && !clear) begin
      slot[wrPtr] <= pushData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  // R3
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop && !clear) |=> $stable(count));
endmodule

// File: rtl/pwm_fifo_ctrl.sv
`timescale 1ns/1ps
module pwm_fifo_ctrl
  import pwm_fifo_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16,
  parameter int CNT_BITS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic [CNT_BITS-1:0] fifoCount,
  input  logic [CNT_W-1:0]  curDuty,
  output pwmCfg_t           cfg,
  output logic [CNT_W-1:0]  periodVal,
  output logic [CNT_W-1:0]  sampleData,
  output pwmStrobe_t        strobe
);
  logic               enReg, polReg, swrPending;
  logic [PRESC_W-1:0] prescReg;
  logic [SRC_W-1:0]   srcReg;
  logic [MODE_W-1:0]  modeReg;
  logic [CNT_W-1:0]   periodReg;
  logic wrCtrl, wrPeriod, unusedWr;

  assign wrCtrl   = wrEn && (addr == OFS_CTRL) && !swrPending;
  assign wrPeriod = wrEn && (addr == OFS_PERIOD) && !swrPending;

  assign strobe.swReset = swrPending;
  assign strobe.push    = wrEn && (addr == OFS_SAMPLE) && !swrPending;
  assign strobe.enStart = wrCtrl && !wrData[BIT_SWR] && wrData[BIT_EN] && !enReg;

  assign sampleData = wrData[CNT_W-1:0];
  assign periodVal  = periodReg;
  assign cfg = '{en: enReg, presc: prescReg, clkSrc: srcReg, pol: polReg};

  assign unusedWr = ^{wrData[DATA_W-1:CTRL_TOP], wrData[MODE_LSB-1:BIT_POL+1],
                      wrData[BIT_SWR-1:BIT_EN+1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg      <= 1'b0;
      polReg     <= 1'b0;
      prescReg   <= '0;
      srcReg     <= '0;
      modeReg    <= '0;
      swrPending <= 1'b0;
    end else if (swrPending) begin
      enReg      <= 1'b0;
      polReg     <= 1'b0;
      prescReg   <= '0;
      srcReg     <= '0;
      modeReg    <= '0;
      swrPending <= 1'b0;
    end else if (wrCtrl) begin
      if (wrData[BIT_SWR]) begin
        swrPending <= 1'b1;
        enReg      <= 1'b0;
        polReg     <= 1'b0;
        prescReg   <= '0;
        srcReg     <= '0;
        modeReg    <= '0;
      end else begin
        enReg    <= wrData[BIT_EN];
        polReg   <= wrData[BIT_POL];
        prescReg <= wrData[PRESC_LSB +: PRESC_W];
        srcReg   <= wrData[SRC_LSB +: SRC_W];
        modeReg  <= wrData[MODE_LSB +: MODE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         periodReg <= '0;
    else if (wrPeriod) periodReg <= wrData[CNT_W-1:0];
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (addr)
        OFS_CTRL: begin
          rdData[BIT_EN]               = enReg;
          rdData[BIT_SWR]              = swrPending;
          rdData[PRESC_LSB +: PRESC_W] = prescReg;
          rdData[SRC_LSB +: SRC_W]     = srcReg;
          rdData[BIT_POL]              = polReg;
          rdData[MODE_LSB +: MODE_W]   = modeReg;
        end
        OFS_STATUS: rdData[CNT_BITS-1:0] = fifoCount;
        OFS_SAMPLE: rdData[CNT_W-1:0]    = curDuty;
        OFS_PERIOD: rdData[CNT_W-1:0]    = periodReg;
        default:    rdData = '0;
      endcase
    end
  end

  // R8
  swr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    swrPending |=> (!swrPending && !enReg && prescReg == '0 && !polReg));
endmodule

// File: rtl/pwm_fifo_datapath.sv
`timescale 1ns/1ps
module pwm_fifo_datapath
  import pwm_fifo_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DEPTH = 4,
  localparam int CNT_BITS = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  pwmCfg_t             cfg,
  input  logic [CNT_W-1:0]    periodVal,
  input  logic [CNT_W-1:0]    sampleData,
  input  pwmStrobe_t          strobe,
  output logic [CNT_BITS-1:0] fifoCount,
  output logic [CNT_W-1:0]    curDuty,
  output logic                pwmOut
);
  logic [PRESC_W-1:0] preCnt;
  logic [CNT_W:0]     cnt, lim;
  logic [CNT_W-1:0]   duty, headData;
  logic running, tick, atEnd, rollover, fifoEmpty, pop;

  assign running  = cfg.en && (cfg.clkSrc != '0);
  assign tick     = running && (preCnt >= cfg.presc);
  assign lim      = (CNT_W+1)'(periodVal) + 1'b1;
  assign atEnd    = (cnt >= lim);
  assign rollover = tick && atEnd;
  assign pop      = (rollover || strobe.enStart) && !fifoEmpty;

  pwm_sample_fifo #(.WIDTH(CNT_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (strobe.swReset),
    .push     (strobe.push),
    .pop      (pop),
    .pushData (sampleData),
    .headData (headData),
    .count    (fifoCount),
    .empty    (fifoEmpty)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          preCnt <= '0;
    else if (!cfg.en || strobe.swReset) preCnt <= '0;
    else if (running)                   preCnt <= tick ? '0 : preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          cnt <= '0;
    else if (!cfg.en || strobe.swReset) cnt <= '0;
    else if (tick)                      cnt <= atEnd ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               duty <= '0;
    else if (strobe.swReset) duty <= '0;
    else if (pop)            duty <= headData;
  end

  assign curDuty = duty;
  assign pwmOut  = cfg.en && ((cnt < (CNT_W+1)'(duty)) ^ cfg.pol);

  // R5
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rollover || strobe.enStart || strobe.swReset) |=> $stable(duty));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.en |=> (cnt == '0));

  // R9
  src_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.en && cfg.clkSrc == '0 && $past(cfg.en)) |-> $stable(cnt));
endmodule

// File: rtl/pwm_fifo_gen.sv
`timescale 1ns/1ps
module pwm_fifo_gen
  import pwm_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  output logic              pwmOut
);
  localparam int CNT_BITS = $clog2(DEPTH + 1);

  pwmCfg_t             cfg;
  pwmStrobe_t          strobe;
  logic [CNT_W-1:0]    periodVal, sampleData, curDuty;
  logic [CNT_BITS-1:0] fifoCount;

  pwm_fifo_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CNT_BITS(CNT_BITS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addr       (busAddr),
    .wrEn       (busWrEn),
    .wrData     (busWrData),
    .rdEn       (busRdEn),
    .rdData     (busRdData),
    .fifoCount  (fifoCount),
    .curDuty    (curDuty),
    .cfg        (cfg),
    .periodVal  (periodVal),
    .sampleData (sampleData),
    .strobe     (strobe)
  );

  pwm_fifo_datapath #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfg        (cfg),
    .periodVal  (periodVal),
    .sampleData (sampleData),
    .strobe     (strobe),
    .fifoCount  (fifoCount),
    .curDuty    (curDuty),
    .pwmOut     (pwmOut)
  );
endmodule

// File: tb/pwm_fifo_gen_test.sv
`timescale 1ns/1ps
module pwm_fifo_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        pwmOut;

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SAMP = 5'h0C, A_PER = 5'h10;

  int nCmp = 0, nBad = 0;
  bit done = 1'b0;

  pwm_fifo_gen uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData), .pwmOut(pwmOut)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  // entered just after a falling edge; returns at the next falling edge
  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    busAddr = a; busRdEn = 1'b1;
    #2;
    d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic expectReg(input logic [4:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    busRead(a, v);
    check(v == exp, tag, v, exp);
  endtask

  task automatic softReset();
    busWrite(A_CTRL, 32'h8);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    expectReg(A_CTRL, 0, "R10 ctrl after reset");
    expectReg(A_STAT, 0, "R10 status after reset");
    expectReg(A_SAMP, 0, "R10 sample after reset");
    expectReg(A_PER,  0, "R10 period after reset");
    check(pwmOut == 1'b0, "R10 output after reset", pwmOut, 0);
    expectReg(5'h08, 0, "R1 unmapped address");

    // sweep prescaler, period and polarity
    begin
      int cfgIdx = 0;
      for (int p = 0; p < 3; p++) begin
        for (int ti = 0; ti < 3; ti++) begin
          for (int pol = 0; pol < 2; pol++) begin
            int t, n, l, dq[4], disc, badCnt, firstC, firstAct, firstExp;
            logic [3:0] mode;
            logic [31:0] ctrlWord;
            t = (ti == 2) ? 3 : ti;
            n = p + 1;
            l = t + 2;
            for (int i = 0; i < 4; i++) dq[i] = (i * 3 + cfgIdx) % (l + 1);
            disc = (dq[3] == 0) ? l : 0;
            mode = cfgIdx[0] ? 4'hF : 4'h0;
            softReset();
            busWrite(A_PER, t);
            for (int i = 0; i < 4; i++) busWrite(A_SAMP, dq[i]);
            busWrite(A_SAMP, disc);
            expectReg(A_STAT, 4, "R3 status full after five writes");
            ctrlWord = 32'(1 | (p << 4) | (1 << 16) | (pol << 18)) | (32'(mode) << 22);
            busWrite(A_CTRL, ctrlWord);
            badCnt = 0; firstC = 0; firstAct = 0; firstExp = 0;
            for (int c = 0; c < 5 * l * n; c++) begin
              int k, pidx, cm, d, e;
              k = c / n;
              pidx = k / l;
              cm = k % l;
              d = (pidx < 4) ? dq[pidx] : dq[3];
              e = ((cm < d) ? 1 : 0) ^ pol;
              if (pwmOut !== e[0]) begin
                if (badCnt == 0) begin firstC = c; firstAct = pwmOut; firstExp = e; end
                badCnt++;
              end
              @(negedge clk);
            end
            check(badCnt == 0, $sformatf("R4 R5 R6 R2 waveform p=%0d t=%0d pol=%0d cycle=%0d",
                  p, t, pol, firstC), firstAct, firstExp);
            expectReg(A_CTRL, ctrlWord, "R1 R2 control readback");
            expectReg(A_STAT, 0, "R3 queue drained after run");
            expectReg(A_SAMP, dq[3], "R5 last duty kept");
            busWrite(A_CTRL, 0);
            badCnt = 0;
            for (int c = 0; c < 2 * l * n + 4; c++) begin
              if (pwmOut !== 1'b0) badCnt++;
              @(negedge clk);
            end
            check(badCnt == 0, "R7 output low after writing 0", badCnt, 0);
            cfgIdx++;
          end
        end
      end
    end

    // R7 polarity set while disabled
    busWrite(A_CTRL, 32'h0004_0000);
    check(pwmOut == 1'b0, "R7 disabled with polarity set", pwmOut, 0);

    // R8 software reset
    softReset();
    busWrite(A_PER, 5);
    busWrite(A_SAMP, 1);
    busWrite(A_SAMP, 2);
    busWrite(A_SAMP, 3);
    busWrite(A_CTRL, 32'h0001_0001);
    repeat (3) @(negedge clk);
    busWrite(A_CTRL, 32'h8);
    expectReg(A_CTRL, 32'h8, "R8 reset bit visible");
    @(negedge clk);
    expectReg(A_CTRL, 0, "R8 reset bit cleared");
    expectReg(A_STAT, 0, "R8 queue emptied");
    expectReg(A_SAMP, 0, "R8 duty cleared");
    expectReg(A_PER, 5, "R8 period kept");
    check(pwmOut == 1'b0, "R8 output low", pwmOut, 0);
    busWrite(A_SAMP, 4);
    busWrite(A_CTRL, 32'h0001_0001);
    check(pwmOut == 1'b1, "R8 fresh duty after reset", pwmOut, 1);
    expectReg(A_SAMP, 4, "R8 first sample after reset");

    // R9 clock source off
    softReset();
    busWrite(A_PER, 3);
    busWrite(A_SAMP, 2);
    busWrite(A_CTRL, 32'h0000_0001);
    begin
      int bad = 0;
      for (int c = 0; c < 40; c++) begin
        if (pwmOut !== 1'b1) bad++;
        @(negedge clk);
      end
      check(bad == 0, "R9 counter frozen with source 0", bad, 0);
    end
    expectReg(A_STAT, 0, "R9 sample taken at enable");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule